// File: doc/BRIEF.md
# Partial-Word Load Return Merger

This block sits between the memory return path and the destination write port of a vector load unit. Each accepted return carries one to four consecutive 32-bit words. The block turns that return into write data and per-byte write enables for the same number of consecutive destination words. It passes the returned bits through with no format conversion.

Three load kinds are supported: full-word loads, low-half loads and high-half loads. A half-word load sends its 16 bits into one half of a register-file destination and keeps the other half. The block does this in two ways at once: it merges the destination's previous contents into the write data, and it drives byte enables that cover only the written half. When the destination is the shared on-chip scratchpad, the half rule does not apply and the whole returned word is written.

The return side uses a valid/ready handshake. The write strobe appears one clock after acceptance.

Top module: `ldret_merge`

## Requirements
- R1: `ret_ready` is 0 while `rst_n` is low and rises within four clocks of reset release. A return is accepted on every rising edge where `ret_valid` and `ret_ready` are both 1.
- R2: A return accepted with an effective word count of at least 1 produces `wr_valid`=1 during the following clock cycle only. If nothing is accepted at an edge, `wr_valid` is 0 after it.
- R3: Word lane i (bits [32i+31:32i] of the data buses, bits [4i+3:4i] of `wr_be`) is active when i is below the effective count. The effective count is `ret_count`, with values above 4 treated as 4. An inactive lane writes data 0 with enables 4'b0000.
- R4: When `ret_kind`=2'b00 (full word) or 2'b11 (treated as full word), each active lane writes the returned word unchanged with enables 4'b1111, whatever `old_data` holds.
- R5: When `ret_kind`=2'b01 (low half) and `ret_to_shared`=0, each active lane writes {old[31:16], ret[15:0]} with enables 4'b0011.
- R6: When `ret_kind`=2'b10 (high half) and `ret_to_shared`=0, each active lane writes {ret[15:0], old[15:0]} with enables 4'b1100. The returned half always comes from bits [15:0] of the memory word.
- R7: When `ret_to_shared`=1, each active lane writes the whole returned word with enables 4'b1111 for every load kind, and `wr_to_shared` is 1 with the strobe.
- R8: A return accepted with `ret_count`=0 produces no write strobe.
- R9: While `rst_n` is low, `wr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | Memory return valid |
| ret_ready | output | 1 | Block can take a return |
| ret_kind | input | 2 | Load kind: 00 full, 01 low half, 10 high half, 11 full |
| ret_to_shared | input | 1 | Destination is the shared scratchpad |
| ret_count | input | 3 | Number of words in the return (0..4, above 4 clamps) |
| ret_data | input | 128 | Returned memory words, word i in bits [32i+31:32i] |
| old_data | input | 128 | Previous destination register contents |
| wr_valid | output | 1 | Write strobe |
| wr_data | output | 128 | Merged write data |
| wr_be | output | 16 | Byte write enables |
| wr_to_shared | output | 1 | Write targets the shared scratchpad |

## Verification
The hardest case to reach from the ports is a half-word load whose kept half is wrong. Such a fault only shows when `old_data` and the upper bits of the returned word hold different, distinctive values in the same lanes. The stimulus therefore sets returned and previous contents to unrelated patterns in every lane, and it runs each half kind with both destinations. It also places zero-count and over-range-count returns back to back between valid returns, so that a stale or missing strobe, or a wrongly clamped lane mask, shows up in the very next compared cycle.

// File: rtl/ldret_pkg.sv
package ldret_pkg;
  typedef enum logic [1:0] {
    KIND_FULL    = 2'b00,
    KIND_HALF_LO = 2'b01,
    KIND_HALF_HI = 2'b10,
    KIND_RSVD    = 2'b11
  } load_kind_e;
endpackage

// File: rtl/ldret_rst_sync.sv
module ldret_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ldret_lane.sv
module ldret_lane
  import ldret_pkg::*;
#(
  parameter int DW_BITS = 32
) (
  input  logic [1:0]           kind,
  input  logic                 to_shared,
  input  logic                 lane_on,
  input  logic [DW_BITS-1:0]   ret_word,
  input  logic [DW_BITS-1:0]   old_word,
  output logic [DW_BITS-1:0]   merged_word,
  output logic [DW_BITS/8-1:0] byte_en
);
  localparam int HALF = DW_BITS / 2;
  localparam int BPW  = DW_BITS / 8;
  localparam int HB   = BPW / 2;

  load_kind_e kind_e;
  assign kind_e = load_kind_e'(kind);

  always_comb begin
    merged_word = '0;
    byte_en     = '0;
    if (lane_on) begin
      if (to_shared) begin
        merged_word = ret_word;
        byte_en     = '1;
      end else begin
        case (kind_e)
          KIND_HALF_LO: begin
            merged_word = {old_word[DW_BITS-1:HALF], ret_word[HALF-1:0]};
            byte_en     = {{HB{1'b0}}, {HB{1'b1}}};
          end
          KIND_HALF_HI: begin
            merged_word = {ret_word[HALF-1:0], old_word[HALF-1:0]};
            byte_en     = {{HB{1'b1}}, {HB{1'b0}}};
          end
          default: begin
            merged_word = ret_word;
            byte_en     = '1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ldret_merge.sv
module ldret_merge
  import ldret_pkg::*;
#(
  parameter int NUM_DW  = 4,
  parameter int DW_BITS = 32,
  parameter int CNT_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ret_valid,
  output logic                          ret_ready,
  input  logic [1:0]                    ret_kind,
  input  logic                          ret_to_shared,
  input  logic [CNT_W-1:0]              ret_count,
  input  logic [NUM_DW*DW_BITS-1:0]     ret_data,
  input  logic [NUM_DW*DW_BITS-1:0]     old_data,
  output logic                          wr_valid,
  output logic [NUM_DW*DW_BITS-1:0]     wr_data,
  output logic [NUM_DW*DW_BITS/8-1:0]   wr_be,
  output logic                          wr_to_shared
);
  localparam int BPW    = DW_BITS / 8;
  localparam int DATA_W = NUM_DW * DW_BITS;
  localparam int BE_W   = NUM_DW * BPW;

  logic rst_q_n;

  ldret_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  // handshake state
  logic ready_q, ready_d;
  logic accept;

  always_comb begin
    ready_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ready_q <= 1'b0;
    else          ready_q <= ready_d;
  end

  assign ret_ready = ready_q;
  assign accept    = ret_valid & ready_q;

  // word count clamp and lane mask
  logic [CNT_W-1:0]  eff_cnt;
  logic [NUM_DW-1:0] lane_on;

  always_comb begin
    if (ret_count > CNT_W'(NUM_DW)) eff_cnt = CNT_W'(NUM_DW);
    else                            eff_cnt = ret_count;
  end

  logic [DATA_W-1:0] lane_data;
  logic [BE_W-1:0]   lane_be;

  for (genvar gi = 0; gi < NUM_DW; gi++) begin : g_lane
    assign lane_on[gi] = (CNT_W'(gi) < eff_cnt);

    ldret_lane #(.DW_BITS(DW_BITS)) u_lane (
      .kind        (ret_kind),
      .to_shared   (ret_to_shared),
      .lane_on     (lane_on[gi]),
      .ret_word    (ret_data[gi*DW_BITS +: DW_BITS]),
      .old_word    (old_data[gi*DW_BITS +: DW_BITS]),
      .merged_word (lane_data[gi*DW_BITS +: DW_BITS]),
      .byte_en     (lane_be[gi*BPW +: BPW])
    );
  end

  // output stage next state
  logic              wv_d, wv_q;
  logic [DATA_W-1:0] wd_d, wd_q;
  logic [BE_W-1:0]   wb_d, wb_q;
  logic              ws_d, ws_q;
  logic              load_en;

  assign load_en = accept;

  always_comb begin
    wv_d = accept && (eff_cnt != '0);
    wd_d = wd_q;
    wb_d = wb_q;
    ws_d = ws_q;
    if (load_en) begin
      wd_d = lane_data;
      wb_d = lane_be;
      ws_d = ret_to_shared;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wv_q <= 1'b0;
      wd_q <= '0;
      wb_q <= '0;
      ws_q <= 1'b0;
    end else begin
      wv_q <= wv_d;
      wd_q <= wd_d;
      wb_q <= wb_d;
      ws_q <= ws_d;
    end
  end

  assign wr_valid     = wv_q;
  assign wr_data      = wd_q;
  assign wr_be        = wb_q;
  assign wr_to_shared = ws_q;
endmodule

// File: rtl/ldret_merge_chk.sv
module ldret_merge_chk #(
  parameter int NUM_DW  = 4,
  parameter int DW_BITS = 32,
  parameter int CNT_W   = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ret_valid,
  input logic                        ret_ready,
  input logic [1:0]                  ret_kind,
  input logic                        ret_to_shared,
  input logic [CNT_W-1:0]            ret_count,
  input logic [NUM_DW*DW_BITS-1:0]   ret_data,
  input logic [NUM_DW*DW_BITS-1:0]   old_data,
  input logic                        wr_valid,
  input logic [NUM_DW*DW_BITS-1:0]   wr_data,
  input logic [NUM_DW*DW_BITS/8-1:0] wr_be,
  input logic                        wr_to_shared
);
  localparam int HALF = DW_BITS / 2;

  logic acc;
  assign acc = ret_valid && ret_ready;

  p_idle_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !wr_valid);

  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ret_count != '0) |=> wr_valid);

  p_zero_count_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ret_count == '0) |=> !wr_valid);

  p_full_passthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ret_count != '0 && !ret_to_shared && ret_kind == 2'b00)
    |=> (wr_data[DW_BITS-1:0] == $past(ret_data[DW_BITS-1:0])) && (wr_be[3:0] == 4'b1111));

  p_low_keeps_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ret_count != '0 && !ret_to_shared && ret_kind == 2'b01)
    |=> (wr_data[DW_BITS-1:HALF] == $past(old_data[DW_BITS-1:HALF])) && (wr_be[3:0] == 4'b0011));

  p_high_keeps_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ret_count != '0 && !ret_to_shared && ret_kind == 2'b10)
    |=> (wr_data[HALF-1:0] == $past(old_data[HALF-1:0]))
        && (wr_data[DW_BITS-1:HALF] == $past(ret_data[HALF-1:0])) && (wr_be[3:0] == 4'b1100));

  p_shared_whole_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ret_count != '0 && ret_to_shared)
    |=> wr_to_shared && (wr_data[DW_BITS-1:0] == $past(ret_data[DW_BITS-1:0])) && (wr_be[3:0] == 4'b1111));

  p_lane_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ret_count == 3'd1) |=> (wr_be[NUM_DW*DW_BITS/8-1:4] == '0));

  p_ready_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ready |=> ret_ready);

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r9: assert (!wr_valid);
    end
  end
endmodule

bind ldret_merge ldret_merge_chk #(
  .NUM_DW  (NUM_DW),
  .DW_BITS (DW_BITS),
  .CNT_W   (CNT_W)
) u_chk (.*);

// File: tb/tb_ldret_merge.sv
module tb_ldret_merge;
  localparam int NUM_DW  = 4;
  localparam int DW_BITS = 32;
  localparam int CNT_W   = 3;
  localparam int DATA_W  = NUM_DW * DW_BITS;
  localparam int BE_W    = NUM_DW * DW_BITS / 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ret_valid;
  logic              ret_ready;
  logic [1:0]        ret_kind;
  logic              ret_to_shared;
  logic [CNT_W-1:0]  ret_count;
  logic [DATA_W-1:0] ret_data;
  logic [DATA_W-1:0] old_data;
  logic              wr_valid;
  logic [DATA_W-1:0] wr_data;
  logic [BE_W-1:0]   wr_be;
  logic              wr_to_shared;

  always #5 clk = ~clk;

  ldret_merge #(.NUM_DW(NUM_DW), .DW_BITS(DW_BITS), .CNT_W(CNT_W)) dut (
    .clk, .rst_n, .ret_valid, .ret_ready, .ret_kind, .ret_to_shared,
    .ret_count, .ret_data, .old_data, .wr_valid, .wr_data, .wr_be, .wr_to_shared
  );

  typedef struct {
    int                due;
    logic              valid;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
    logic              shared;
    string             tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // monitor: compares design output with the scoreboard head
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.valid)
        check(wr_valid && wr_data == e.data && wr_be == e.be && wr_to_shared == e.shared, e.tag,
              $sformatf("v=%0b d=%h be=%h s=%0b", wr_valid, wr_data, wr_be, wr_to_shared),
              $sformatf("v=1 d=%h be=%h s=%0b", e.data, e.be, e.shared));
      else
        check(!wr_valid, e.tag, $sformatf("v=%0b", wr_valid), "v=0");
    end
  end

  function automatic logic [31:0] pat(input int seed, input int i, input bit old);
    logic [15:0] hi, lo;
    hi = old ? 16'hD000 + 16'(seed * 7 + i) : 16'hA500 + 16'(seed * 3 + i);
    lo = old ? 16'h0E00 + 16'(seed + i * 5) : 16'h3C00 + 16'(seed * 11 + i * 2);
    return {hi, lo};
  endfunction

  // driver: applies one return for one cycle and posts the expected write
  task automatic send(input logic [1:0] kind, input logic shr, input int cnt, input int seed, input string tag);
    exp_t e;
    int   eff;
    @(posedge clk); #1;
    ret_valid     = 1'b1;
    ret_kind      = kind;
    ret_to_shared = shr;
    ret_count     = CNT_W'(cnt);
    for (int i = 0; i < NUM_DW; i++) begin
      ret_data[i*32 +: 32] = pat(seed, i, 1'b0);
      old_data[i*32 +: 32] = pat(seed, i, 1'b1);
    end
    eff = (cnt > NUM_DW) ? NUM_DW : cnt;
    e.due = cyc + 1; e.tag = tag; e.shared = shr;
    e.valid = (eff != 0);
    e.data = '0; e.be = '0;
    for (int i = 0; i < eff; i++) begin
      logic [31:0] r, o;
      r = ret_data[i*32 +: 32];
      o = old_data[i*32 +: 32];
      if (shr || kind == 2'b00 || kind == 2'b11) begin
        e.data[i*32 +: 32] = r; e.be[i*4 +: 4] = 4'b1111;
      end else if (kind == 2'b01) begin
        e.data[i*32 +: 32] = {o[31:16], r[15:0]}; e.be[i*4 +: 4] = 4'b0011;
      end else begin
        e.data[i*32 +: 32] = {r[15:0], o[15:0]}; e.be[i*4 +: 4] = 4'b1100;
      end
    end
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(posedge clk); #1;
    ret_valid = 1'b0;
    ret_count = 3'd4;
    e.due = cyc + 1; e.valid = 1'b0; e.data = '0; e.be = '0; e.shared = 1'b0; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ret_valid = 1'b0; ret_kind = 2'b00; ret_to_shared = 1'b0;
    ret_count = '0; ret_data = '0; old_data = '0;
    repeat (3) @(negedge clk);
    check(!wr_valid, "R9 reset strobe", $sformatf("%0b", wr_valid), "0");
    check(!ret_ready, "R1 ready in reset", $sformatf("%0b", ret_ready), "0");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ret_ready, "R1 ready after reset", $sformatf("%0b", ret_ready), "1");
    check(!wr_valid, "R2 no strobe when idle", $sformatf("%0b", wr_valid), "0");

    send(2'b00, 1'b0, 4, 1, "R4 full four words");
    send(2'b01, 1'b0, 2, 2, "R5 low half two words");
    send(2'b10, 1'b0, 3, 3, "R6 high half three words");
    send(2'b01, 1'b1, 1, 4, "R7 shared low half");
    send(2'b10, 1'b1, 4, 5, "R7 shared high half");
    send(2'b00, 1'b0, 0, 6, "R8 zero count");
    send(2'b10, 1'b0, 7, 7, "R3 count clamp high half");
    send(2'b11, 1'b0, 2, 8, "R4 reserved kind as full");
    idle("R2 strobe single cycle");
    send(2'b01, 1'b0, 1, 9, "R3 single lane low half");
    send(2'b00, 1'b1, 3, 10, "R7 shared full");
    send(2'b00, 1'b0, 0, 11, "R8 zero count after valid");
    send(2'b10, 1'b0, 4, 12, "R6 high half four words");
    send(2'b01, 1'b0, 5, 13, "R3 count five low half");
    idle("R2 idle after burst");
    idle("R2 idle again");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2 scoreboard drained", $sformatf("%0d", q.size()), "0");
    check(ret_ready, "R1 ready held", $sformatf("%0b", ret_ready), "1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule